// File: doc/BRIEF.md
# Set-Associative Translation Lookaside Buffer

This block caches virtual-to-physical page translations for a processor whose page tables are walked in hardware. It holds 32 translations as 8 sets of 4 ways. The same entries serve instruction and data accesses, and no entries are reserved for the kernel. A lookup presents a 20-bit virtual page number. In the same cycle the block answers with hit or miss, the 20-bit physical frame number and an 8-bit field of protection and status bits.

After a miss, the external page walker writes the translation it found through the fill port. The fill goes into the lowest-numbered invalid way of the indexed set. If the set is full, a 3-bit tree pseudo-LRU state kept for each set picks the victim. Entries carry no address-space tag. When the page-directory base changes, software pulses the flush input, which drops every translation in one cycle.

Top module: `tlb_xlat`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge) every entry is invalid, and every lookup misses until a fill is made.
- R2: A lookup with lk_valid high and flush low hits in the same cycle, combinationally, when a valid entry in the indexed set holds the tag. lk_pfn and lk_attr then carry that entry's frame number and attribute bits. On a miss both outputs are zero.
- R3: The set index is lk_vpn[2:0] (virtual address bits 14..12) and the tag is lk_vpn[19:3]. Entries with the same tag in different sets are independent.
- R4: A fill into a set with an invalid way writes the lowest-numbered invalid way. Four distinct fills into one empty set therefore all remain resident.
- R5: A fill into a full set evicts the way named by the set's tree bits b[2:0]. If b0 is 0, the way is 0 when b1 is 0 and 1 when b1 is 1. If b0 is 1, the way is 2 when b2 is 0 and 3 when b2 is 1.
- R6: Every hit and every fill updates the tree bits of its set so that they point away from the accessed way. b0 is set to 1 for ways 0 and 1 and to 0 for ways 2 and 3. For ways 0 and 1, b1 is set to the complement of the way's low bit; for ways 2 and 3, b2 is set to it. The victim that follows is never the way accessed last.
- R7: A fill whose page number is already resident overwrites that entry in place, so a page number never occupies two ways.
- R8: flush invalidates all entries and clears all tree bits at the next edge. In the same cycle it forces the lookup to miss and discards a simultaneous fill.
- R9: With lk_valid low, lk_hit is low whatever lk_vpn holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_hit | output | 1 | Lookup hit |
| lk_pfn | output | 20 | Physical frame number on hit, else zero |
| lk_attr | output | 8 | Protection and status bits on hit, else zero |
| fill_en | input | 1 | Write a translation |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_pfn | input | 20 | Physical frame number to install |
| fill_attr | input | 8 | Attribute bits to install |

## Verification
The assertions check the following on every cycle:
- At most one way matches a lookup.
- A fill goes to a free way whenever the set has one.
- A victim is never the way that hit in the previous cycle.
- A fill is visible to a lookup in the next cycle.
- A flush leaves nothing to hit.
- Nothing hits straight after reset.

Only the bench's directed sequences can show the exact victim order produced by the tree bits across several fills and hits. They also show the frame numbers returned after evictions and in-place overwrites, and that a flush discards a fill arriving in the same cycle.

// File: rtl/tlb_pkg.sv
// Shared definitions for the translation buffer: way count, tree-bit
// width and the pseudo-LRU helper functions. Assumes exactly four ways.
package tlb_pkg;
    localparam int NWAYS  = 4;
    localparam int LRU_W  = 3;
    localparam int WAY_W  = 2;

    typedef logic [WAY_W-1:0] way_t;
    typedef logic [LRU_W-1:0] lru_t;

    // Way named by the tree bits when the set is full.
    function automatic way_t plru_victim(input lru_t b);
        return b[0] ? {1'b1, b[2]} : {1'b0, b[1]};
    endfunction

    // Tree bits after way w is accessed: point away from w.
    function automatic lru_t plru_touch(input lru_t b, input way_t w);
        lru_t r;
        r    = b;
        r[0] = ~w[1];
        if (w[1]) r[2] = ~w[0];
        else      r[1] = ~w[0];
        return r;
    endfunction

    // Lowest-numbered clear bit of a validity vector.
    function automatic way_t lowest_free(input logic [NWAYS-1:0] v);
        way_t r;
        r = '0;
        for (int i = NWAYS - 1; i >= 0; i--) begin
            if (!v[i]) r = way_t'(i);
        end
        return r;
    endfunction

    // Index of the set bit of a one-hot vector (zero if none).
    function automatic way_t onehot_index(input logic [NWAYS-1:0] v);
        way_t r;
        r = '0;
        for (int i = 0; i < NWAYS; i++) begin
            if (v[i]) r = r | way_t'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/tlb_way_array.sv
// One way of the translation buffer: a valid bit, tag, frame number and
// attributes per set. It has two read ports, one for lookups and one for
// probing the fill set, and one write port. Assumes the caller has
// already masked wr_en with flush.
module tlb_way_array #(
    parameter  int SETS   = 8,
    parameter  int TAG_W  = 17,
    parameter  int PFN_W  = 20,
    parameter  int ATTR_W = 8,
    localparam int IDX_W  = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [PFN_W-1:0]  wr_pfn,
    input  logic [ATTR_W-1:0] wr_attr,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [TAG_W-1:0]  rd_tag,
    output logic              rd_match,
    output logic [PFN_W-1:0]  rd_pfn,
    output logic [ATTR_W-1:0] rd_attr,
    input  logic [IDX_W-1:0]  pr_idx,
    input  logic [TAG_W-1:0]  pr_tag,
    output logic              pr_valid,
    output logic              pr_match
);
    logic [SETS-1:0]   valid_q;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [PFN_W-1:0]  pfn_q  [SETS];
    logic [ATTR_W-1:0] attr_q [SETS];

    // Valid bits: cleared by reset or flush, set by a write.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) valid_q <= '0;
        else if (wr_en)      valid_q[wr_idx] <= 1'b1;
    end

    // Payload storage, written without reset.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_tag;
            pfn_q[wr_idx]  <= wr_pfn;
            attr_q[wr_idx] <= wr_attr;
        end
    end

    // Lookup read port.
    always_comb begin
        rd_match = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
        rd_pfn   = pfn_q[rd_idx];
        rd_attr  = attr_q[rd_idx];
    end

    // Fill probe port.
    always_comb begin
        pr_valid = valid_q[pr_idx];
        pr_match = valid_q[pr_idx] && (tag_q[pr_idx] == pr_tag);
    end
endmodule

// File: rtl/tlb_repl.sv
// Replacement control: keeps 3 tree pseudo-LRU bits per set and picks
// the way a fill writes. An existing copy of the page comes first, then
// the lowest invalid way, then the tree victim. Assumes hit_en and
// fill_en are already masked with flush.
module tlb_repl import tlb_pkg::*; #(
    parameter  int SETS  = 8,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             hit_en,
    input  logic [IDX_W-1:0] hit_idx,
    input  way_t             hit_way,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [NWAYS-1:0] fill_valid,
    input  logic [NWAYS-1:0] fill_match,
    output way_t             fill_way
);
    lru_t lru_q [SETS];
    lru_t lru_d [SETS];

    // Way selection for a fill.
    always_comb begin
        if (|fill_match)       fill_way = onehot_index(fill_match);
        else if (!(&fill_valid)) fill_way = lowest_free(fill_valid);
        else                   fill_way = plru_victim(lru_q[fill_idx]);
    end

    // Next tree bits: hit update first, then fill update.
    always_comb begin
        for (int s = 0; s < SETS; s++) lru_d[s] = lru_q[s];
        if (hit_en)  lru_d[hit_idx]  = plru_touch(lru_d[hit_idx], hit_way);
        if (fill_en) lru_d[fill_idx] = plru_touch(lru_d[fill_idx], fill_way);
    end

    // Tree-bit registers, cleared by reset or flush.
    always_ff @(posedge clk) begin
        for (int s = 0; s < SETS; s++) begin
            if (!rst_n || flush) lru_q[s] <= '0;
            else                 lru_q[s] <= lru_d[s];
        end
    end
endmodule

// File: rtl/tlb_xlat.sv
// Top of the translation buffer: four way arrays, a combinational hit
// mux and the replacement control. Lookups answer in the same cycle.
// Assumes fills come from a page walker after a miss.
module tlb_xlat import tlb_pkg::*; #(
    parameter int SETS   = 8,
    parameter int VPN_W  = 20,
    parameter int PFN_W  = 20,
    parameter int ATTR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    output logic              lk_hit,
    output logic [PFN_W-1:0]  lk_pfn,
    output logic [ATTR_W-1:0] lk_attr,
    input  logic              fill_en,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic [ATTR_W-1:0] fill_attr
);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = VPN_W - IDX_W;

    logic [IDX_W-1:0]  lk_idx, fl_idx;
    logic [TAG_W-1:0]  lk_tag, fl_tag;
    logic              fill_go;
    logic [NWAYS-1:0]  way_match, hit_vec, fl_valid_vec, fl_match_vec;
    logic [PFN_W-1:0]  way_pfn  [NWAYS];
    logic [ATTR_W-1:0] way_attr [NWAYS];
    way_t              hit_way, fill_way;

    assign lk_idx  = lk_vpn[IDX_W-1:0];
    assign lk_tag  = lk_vpn[VPN_W-1:IDX_W];
    assign fl_idx  = fill_vpn[IDX_W-1:0];
    assign fl_tag  = fill_vpn[VPN_W-1:IDX_W];
    assign fill_go = fill_en && !flush;

    for (genvar w = 0; w < NWAYS; w++) begin : g_way
        tlb_way_array #(
            .SETS(SETS), .TAG_W(TAG_W), .PFN_W(PFN_W), .ATTR_W(ATTR_W)
        ) u_way (
            .clk      (clk),
            .rst_n    (rst_n),
            .flush    (flush),
            .wr_en    (fill_go && (fill_way == way_t'(w))),
            .wr_idx   (fl_idx),
            .wr_tag   (fl_tag),
            .wr_pfn   (fill_pfn),
            .wr_attr  (fill_attr),
            .rd_idx   (lk_idx),
            .rd_tag   (lk_tag),
            .rd_match (way_match[w]),
            .rd_pfn   (way_pfn[w]),
            .rd_attr  (way_attr[w]),
            .pr_idx   (fl_idx),
            .pr_tag   (fl_tag),
            .pr_valid (fl_valid_vec[w]),
            .pr_match (fl_match_vec[w])
        );
    end

    // Qualify way matches with the request and the flush override.
    assign hit_vec = way_match & {NWAYS{lk_valid && !flush}};
    assign lk_hit  = |hit_vec;
    assign hit_way = onehot_index(hit_vec);

    // AND-OR mux of the matching way's payload; zero on miss.
    always_comb begin
        lk_pfn  = '0;
        lk_attr = '0;
        for (int w = 0; w < NWAYS; w++) begin
            lk_pfn  = lk_pfn  | (way_pfn[w]  & {PFN_W{hit_vec[w]}});
            lk_attr = lk_attr | (way_attr[w] & {ATTR_W{hit_vec[w]}});
        end
    end

    tlb_repl #(.SETS(SETS)) u_repl (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .hit_en     (lk_hit),
        .hit_idx    (lk_idx),
        .hit_way    (hit_way),
        .fill_en    (fill_go),
        .fill_idx   (fl_idx),
        .fill_valid (fl_valid_vec),
        .fill_match (fl_match_vec),
        .fill_way   (fill_way)
    );
endmodule

// File: rtl/tlb_xlat_chk.sv
// Property checker for tlb_xlat, attached by bind. It watches the ports
// plus the match vectors and the way choices made inside the top.
module tlb_xlat_chk import tlb_pkg::*; #(
    parameter  int SETS  = 8,
    parameter  int VPN_W = 20,
    parameter  int PFN_W = 20,
    localparam int IDX_W = $clog2(SETS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             lk_valid,
    input logic [VPN_W-1:0] lk_vpn,
    input logic             lk_hit,
    input logic [PFN_W-1:0] lk_pfn,
    input logic             fill_en,
    input logic [VPN_W-1:0] fill_vpn,
    input logic [PFN_W-1:0] fill_pfn,
    input logic [NWAYS-1:0] hit_vec,
    input way_t             hit_way,
    input logic [NWAYS-1:0] fl_valid_vec,
    input logic [NWAYS-1:0] fl_match_vec,
    input way_t             fill_way
);
    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !lk_hit);  // R1

    AST_FILL_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fill_en && !flush) && lk_valid && !flush
         && lk_vpn == $past(fill_vpn)) |-> (lk_hit && lk_pfn == $past(fill_pfn)));  // R2

    AST_FREE_WAY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !flush && !(|fl_match_vec) && !(&fl_valid_vec))
        |-> !fl_valid_vec[fill_way]);  // R4

    AST_NOT_LAST_TOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(lk_hit && !fill_en) && fill_en && !flush
         && (&fl_valid_vec) && !(|fl_match_vec)
         && $past(lk_vpn[IDX_W-1:0]) == fill_vpn[IDX_W-1:0])
        |-> fill_way != $past(hit_way));  // R6

    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));  // R7

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !lk_hit);  // R8
endmodule

bind tlb_xlat tlb_xlat_chk #(.SETS(SETS), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush        (flush),
    .lk_valid     (lk_valid),
    .lk_vpn       (lk_vpn),
    .lk_hit       (lk_hit),
    .lk_pfn       (lk_pfn),
    .fill_en      (fill_en),
    .fill_vpn     (fill_vpn),
    .fill_pfn     (fill_pfn),
    .hit_vec      (hit_vec),
    .hit_way      (hit_way),
    .fl_valid_vec (fl_valid_vec),
    .fl_match_vec (fl_match_vec),
    .fill_way     (fill_way)
);

// File: tb/tlb_xlat_test.sv
// Directed bench for tlb_xlat: one task per scenario, each checking its
// own results. Inputs change on the falling edge; outputs are sampled
// 4 ns later, before the next rising edge.
module tlb_xlat_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        lk_valid = 1'b0;
    logic [19:0] lk_vpn = '0;
    logic        lk_hit;
    logic [19:0] lk_pfn;
    logic [7:0]  lk_attr;
    logic        fill_en = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [19:0] fill_pfn = '0;
    logic [7:0]  fill_attr = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tlb_xlat uut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_hit(lk_hit),
        .lk_pfn(lk_pfn), .lk_attr(lk_attr),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
        .fill_attr(fill_attr)
    );

    function automatic logic [19:0] mk(input int tag, input int set);
        return {tag[16:0], set[2:0]};
    endfunction

    function automatic logic [7:0] attr_of(input logic [19:0] p);
        return p[7:0] ^ 8'h5A;
    endfunction

    task automatic put(input logic [19:0] v, input logic [19:0] p);
        @(negedge clk);
        fill_en = 1'b1; fill_vpn = v; fill_pfn = p; fill_attr = attr_of(p);
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    // Lookup held across one rising edge; expected hit and frame.
    task automatic look(input string req, input logic [19:0] v,
                        input logic eh, input logic [19:0] ep);
        logic [19:0] xp;
        logic [7:0]  xa;
        xp = eh ? ep : 20'h0;
        xa = eh ? attr_of(ep) : 8'h0;
        @(negedge clk);
        lk_valid = 1'b1; lk_vpn = v;
        #4;
        n_chk++;
        if (lk_hit !== eh || lk_pfn !== xp || lk_attr !== xa) begin
            n_bad++;
            $display("FAIL %s vpn=%h: hit=%b pfn=%h attr=%h expected hit=%b pfn=%h attr=%h",
                     req, v, lk_hit, lk_pfn, lk_attr, eh, xp, xa);
        end
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic t_reset();
        look("R1", mk(0, 0), 1'b0, 0);
        look("R1", mk(5, 3), 1'b0, 0);
    endtask

    task automatic t_basic();
        put(mk(1, 0), 20'h11111);
        look("R2", mk(1, 0), 1'b1, 20'h11111);
        look("R2", mk(2, 0), 1'b0, 0);
        look("R3", mk(1, 1), 1'b0, 0);
        put(mk(1, 1), 20'h22222);
        look("R3", mk(1, 0), 1'b1, 20'h11111);
        look("R3", mk(1, 1), 1'b1, 20'h22222);
    endtask

    task automatic t_idle();
        @(negedge clk);
        lk_valid = 1'b0; lk_vpn = mk(1, 0);
        #4;
        n_chk++;
        if (lk_hit !== 1'b0) begin
            n_bad++;
            $display("FAIL R9 idle lookup: hit=%b expected hit=0", lk_hit);
        end
    endtask

    task automatic t_free();
        for (int i = 0; i < 4; i++) put(mk(10 + i, 2), 20'h30000 + 20'(i));
        for (int i = 0; i < 4; i++) look("R4", mk(10 + i, 2), 1'b1, 20'h30000 + 20'(i));
    endtask

    // Set 5: A..D fill ways 0..3; tree bits end at 000.
    task automatic t_tree();
        for (int i = 0; i < 4; i++) put(mk(20 + i, 5), 20'h50000 + 20'(i));
        put(mk(24, 5), 20'h50004);            // E evicts way0 (A); bits 011
        look("R5", mk(20, 5), 1'b0, 0);
        put(mk(25, 5), 20'h50005);            // F evicts way2 (C); bits 110
        look("R5", mk(22, 5), 1'b0, 0);
        put(mk(26, 5), 20'h50006);            // G evicts way1 (B); bits 101
        look("R5", mk(21, 5), 1'b0, 0);
        look("R6", mk(23, 5), 1'b1, 20'h50003); // hit D way3; bits 000
        put(mk(27, 5), 20'h50007);            // H evicts way0 (E)
        look("R6", mk(24, 5), 1'b0, 0);
        look("R6", mk(25, 5), 1'b1, 20'h50005);
        look("R6", mk(26, 5), 1'b1, 20'h50006);
        look("R6", mk(27, 5), 1'b1, 20'h50007);
    endtask

    task automatic t_dup();
        put(mk(30, 3), 20'h60001);
        put(mk(30, 3), 20'h60002);
        look("R7", mk(30, 3), 1'b1, 20'h60002);
        for (int i = 1; i < 4; i++) put(mk(30 + i, 3), 20'h60010 + 20'(i));
        look("R7", mk(30, 3), 1'b1, 20'h60002);
        for (int i = 1; i < 4; i++) look("R7", mk(30 + i, 3), 1'b1, 20'h60010 + 20'(i));
    endtask

    task automatic t_flush();
        put(mk(40, 6), 20'h70000);
        look("R8", mk(40, 6), 1'b1, 20'h70000);
        @(negedge clk);
        flush = 1'b1; lk_valid = 1'b1; lk_vpn = mk(40, 6);
        #4;
        n_chk++;
        if (lk_hit !== 1'b0) begin
            n_bad++;
            $display("FAIL R8 lookup during flush: hit=%b expected hit=0", lk_hit);
        end
        @(negedge clk);
        flush = 1'b0; lk_valid = 1'b0;
        look("R8", mk(40, 6), 1'b0, 0);
        look("R8", mk(23, 5), 1'b0, 0);
        look("R8", mk(1, 0), 1'b0, 0);
        @(negedge clk);
        flush = 1'b1; fill_en = 1'b1; fill_vpn = mk(41, 6);
        fill_pfn = 20'h70001; fill_attr = attr_of(20'h70001);
        @(negedge clk);
        flush = 1'b0; fill_en = 1'b0;
        look("R8", mk(41, 6), 1'b0, 0);
        put(mk(42, 6), 20'h70002);
        look("R8", mk(42, 6), 1'b1, 20'h70002);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_idle();
        t_free();
        t_tree();
        t_dup();
        t_flush();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule